// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag Controller

This block turns the timing events of a real-time clock into status flags and a single interrupt request. A slow tick enable, one clock cycle wide and arriving at the 32.768 kHz rate, drives a free-running divider that produces a periodic event. The rate of that event is chosen by a 4-bit rate-select field. A once-per-second update request starts a fixed warning window of eight ticks (about 244 µs). During that window an update-in-progress status bit is high. When the window ends, the block issues a one-cycle pulse that tells the calendar counters to advance. One tick after that advance (about 30.5 µs), the block samples the alarm-compare input.

Three flags record the periodic, alarm and update-ended events. Software reads them as one status byte. Any read strobe on that byte clears all three flags together. The interrupt request is the OR of every flag ANDed with its enable bit, and the top bit of the status byte mirrors that request. All pins are plain control and status signals. Nothing in this block streams data, so there is no valid/ready handshake and no back-pressure.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, `status_c` is 0x00 and `irq`, `uip` and `upd_go` are low.
- R2: For `rate_sel` values 3 to 15, a periodic event sets status bit 6 on one tick of every 2^(rate_sel-1) ticks. For values 0, 1 and 2, no periodic event ever occurs.
- R3: `uip` rises in the cycle after `upd_req` is accepted and stays high for eight ticks. On the eighth tick, `uip` falls, `upd_go` is high for exactly one cycle, and the update-ended flag (status bit 4) is set in that same cycle.
- R4: On the first tick after `upd_go`, `alarm_match` is sampled. If it is high, the alarm flag (status bit 5) is set. If it is low, the alarm flag is not set.
- R5: Flags are set whatever the enable bits are. The enables gate only `irq` and status bit 7.
- R6: `irq` and status bit 7 are both high exactly when some flag is set together with its enable bit. The enable bits map as `int_en[2]` for periodic, `int_en[1]` for alarm and `int_en[0]` for update-ended.
- R7: A cycle with `stat_rd` high returns the current status byte, and all flags are clear from the next cycle. `irq` falls in that next cycle as well.
- R8: If an event happens in the same cycle as `stat_rd`, its flag is set after that read and is not lost.
- R9: If an event repeats while its flag is still set, the repeat is dropped. A single read clears the flag, and the flag stays clear until a new event happens.
- R10: `upd_req` has no effect while the warning window or the alarm-sample wait is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz rate |
| upd_req | input | 1 | Request to start an update cycle |
| alarm_match | input | 1 | Alarm comparator result |
| rate_sel | input | 4 | Periodic rate select |
| int_en | input | 3 | Enables: [2] periodic, [1] alarm, [0] update-ended |
| stat_rd | input | 1 | Read strobe of the status byte |
| irq | output | 1 | Active-high interrupt request |
| uip | output | 1 | Update-in-progress status bit |
| upd_go | output | 1 | One-cycle pulse: calendar advances |
| status_c | output | 8 | {irq, periodic, alarm, update-ended, 4'b0} |

## Verification
On every cycle, the assertions check the following. A flag is set in the cycle after its event, even when a read arrives at the same time. A read with no coincident event leaves every flag clear. Flags hold their values when there is neither an event nor a read. `upd_go` lasts one cycle and matches the fall of `uip`. No periodic event occurs at the disabled rates.

Some behaviours can only be shown by the bench scenarios, which compare against a behavioural model on every clock. These are the exact period for each rate, the eight-tick window length, the one-tick alarm delay, requests dropped while the block is busy, and the gating of the request by the enables.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned NUM_SRC = 3;
  localparam int unsigned SRC_UPD = 0;
  localparam int unsigned SRC_ALM = 1;
  localparam int unsigned SRC_PER = 2;
  typedef logic [NUM_SRC-1:0] src_vec_t;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WARN  = 2'd1,
    SEQ_ALARM = 2'd2
  } seq_state_t;
endpackage

// File: rtl/rtc_periodic_div.sv
module rtc_periodic_div #(
  parameter int unsigned DIV_W  = 15,
  parameter int unsigned RS_W   = 4,
  parameter int unsigned MIN_RS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [RS_W-1:0] rate_sel,
  output logic            p_evt
);
  localparam logic [DIV_W-1:0] ALL_ONES = {DIV_W{1'b1}};

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic             rate_on;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else if (tick) div_q <= div_q + 1'b1;
  end

  // low (rate_sel-1) bits all ones marks the last tick of a period
  always_comb begin
    rate_on = (rate_sel >= RS_W'(MIN_RS));
    mask    = rate_on ? ~(ALL_ONES << (rate_sel - 1'b1)) : '0;
    p_evt   = tick && rate_on && ((div_q & mask) == mask);
  end

  AST_RATE_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel < RS_W'(MIN_RS)) |-> !p_evt); // R2
endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
  import rtc_irq_pkg::*;
#(
  parameter int unsigned UIP_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic upd_req,
  input  logic alarm_match,
  output logic uip,
  output logic upd_go,
  output logic u_evt,
  output logic a_evt
);
  localparam int unsigned CNT_W = (UIP_TICKS > 1) ? $clog2(UIP_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(UIP_TICKS - 1);

  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             window_end;

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    window_end = 1'b0;
    a_evt      = 1'b0;
    unique case (st_q)
      SEQ_IDLE: if (upd_req) begin
        st_d  = SEQ_WARN;
        cnt_d = '0;
      end
      SEQ_WARN: if (tick) begin
        if (cnt_q == LAST) begin
          st_d       = SEQ_ALARM;
          window_end = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_ALARM: if (tick) begin
        st_d  = SEQ_IDLE;
        a_evt = alarm_match;
      end
      default: st_d = SEQ_IDLE;
    endcase
    u_evt = window_end;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      cnt_q  <= '0;
      upd_go <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      upd_go <= window_end;
    end
  end

  assign uip = (st_q == SEQ_WARN);

  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_go |=> !upd_go); // R3
  AST_UIP_END_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uip) |-> upd_go); // R3
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_ALARM && !tick) |=> !uip); // R10
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank
  import rtc_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t evt,
  input  logic     rd_clr,
  output src_vec_t flags
);
  // set wins over clear; a set flag absorbs repeats
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~{NUM_SRC{rd_clr}}) | evt;
  end

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
      AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt[i] |=> flags[i]); // R8
    end
  endgenerate

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && evt == '0) |=> (flags == '0)); // R7
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && evt == '0) |=> $stable(flags)); // R9
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int unsigned DIV_W     = 15,
  parameter int unsigned RS_W      = 4,
  parameter int unsigned UIP_TICKS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_32k,
  input  logic            upd_req,
  input  logic            alarm_match,
  input  logic [RS_W-1:0] rate_sel,
  input  logic [2:0]      int_en,
  input  logic            stat_rd,
  output logic            irq,
  output logic            uip,
  output logic            upd_go,
  output logic [7:0]      status_c
);
  logic     p_evt, u_evt, a_evt;
  src_vec_t evt;
  src_vec_t flags;

  rtc_periodic_div #(.DIV_W(DIV_W), .RS_W(RS_W), .MIN_RS(3)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick_32k), .rate_sel(rate_sel), .p_evt(p_evt)
  );

  rtc_update_seq #(.UIP_TICKS(UIP_TICKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick_32k), .upd_req(upd_req),
    .alarm_match(alarm_match), .uip(uip), .upd_go(upd_go),
    .u_evt(u_evt), .a_evt(a_evt)
  );

  always_comb begin
    evt          = '0;
    evt[SRC_PER] = p_evt;
    evt[SRC_ALM] = a_evt;
    evt[SRC_UPD] = u_evt;
  end

  rtc_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .rd_clr(stat_rd), .flags(flags)
  );

  assign irq      = |(flags & int_en);
  assign status_c = {irq, flags[SRC_PER], flags[SRC_ALM], flags[SRC_UPD], 4'b0000};

  AST_GO_SETS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    upd_go |-> status_c[4]); // R3
  AST_NO_IRQ_UNENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en == 3'b000) |-> !irq); // R6
endmodule

// File: tb/test_rtc_irq_ctrl.sv
`timescale 1ns/1ps
module test_rtc_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic       upd_req = 1'b0;
  logic       alarm_match = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic [2:0] int_en = 3'd0;
  logic       stat_rd = 1'b0;
  logic       irq, uip, upd_go;
  logic [7:0] status_c;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  bit tick_on = 0;
  int tick_ph = 0;

  always #2 clk = ~clk;

  rtc_irq_ctrl i_rtc_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .upd_req(upd_req),
    .alarm_match(alarm_match), .rate_sel(rate_sel), .int_en(int_en),
    .stat_rd(stat_rd), .irq(irq), .uip(uip), .upd_go(upd_go), .status_c(status_c)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_div = 0, m_st = 0, m_cnt = 0;
  bit m_go = 0;
  bit [2:0] m_flags = 0;
  always @(posedge clk) begin
    bit pe, ae, ue, ngo;
    int mask;
    if (!rst_n) begin
      m_div = 0; m_st = 0; m_cnt = 0; m_go = 0; m_flags = 0;
    end else begin
      pe = 0; ae = 0; ue = 0; ngo = 0;
      if (tick_32k && rate_sel >= 3) begin
        mask = (1 << (rate_sel - 1)) - 1;
        if ((m_div & mask) == mask) pe = 1;
      end
      if (tick_32k) m_div = (m_div + 1) % 32768;
      case (m_st)
        0: if (upd_req) begin m_st = 1; m_cnt = 0; end
        1: if (tick_32k) begin
             if (m_cnt == 7) begin m_st = 2; ngo = 1; ue = 1; end
             else m_cnt++;
           end
        default: if (tick_32k) begin m_st = 0; ae = alarm_match; end
      endcase
      m_go = ngo;
      if (stat_rd) m_flags = 0;
      m_flags = m_flags | {pe, ae, ue};
    end
  end

  // compare every cycle, after the negedge input changes settle
  always @(negedge clk) begin
    bit e_irq;
    #1;
    e_irq = |(m_flags & int_en);
    chk(status_c[6:4] == m_flags, "R2/R3/R4/R8/R9 flags", status_c[6:4], m_flags);
    chk(irq == e_irq && status_c[7] == e_irq, "R6 irq", {irq, status_c[7]}, {e_irq, e_irq});
    chk(uip == (m_st == 1), "R3/R10 uip", uip, (m_st == 1));
    chk(upd_go == m_go, "R3 upd_go", upd_go, m_go);
    chk(status_c[3:0] == 4'h0, "R1 low nibble", status_c[3:0], 0);
  end

  // tick generator: one clock in three
  always @(negedge clk) begin
    tick_ph = (tick_ph + 1) % 3;
    tick_32k <= tick_on && (tick_ph == 0);
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_read();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic do_update(input bit am);
    alarm_match = am;
    upd_req = 1'b1; @(negedge clk); upd_req = 1'b0;
  endtask

  initial begin
    cyc(4);
    #1;
    chk(status_c == 8'h00 && !irq && !uip && !upd_go, "R1 reset state", status_c, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(status_c == 8'h00 && !irq && !uip, "R1 after reset", status_c, 0);
    tick_on = 1;

    // R2 disabled rates
    for (int rs = 0; rs < 3; rs++) begin
      rate_sel = 4'(rs);
      cyc(120);
      #1;
      chk(status_c[6] == 1'b0, "R2 rate off", status_c[6], 0);
    end

    // R2 periodic rates with reads
    int_en = 3'b100;
    foreach (rate_sel[i]) ;
    for (int rs = 3; rs <= 9; rs++) begin
      rate_sel = 4'(rs);
      for (int k = 0; k < 40; k++) begin
        cyc(1 + ($urandom % 50));
        if ($urandom % 2) do_read();
      end
    end

    // R8 read every cycle at fastest rate
    rate_sel = 4'd3;
    for (int k = 0; k < 60; k++) do_read();

    // R5 flags set while enables clear
    int_en = 3'b000;
    do_read();
    cyc(40);
    #1;
    chk(status_c[6] == 1'b1 && irq == 1'b0, "R5 flag without irq", {status_c[6], irq}, 2'b10);
    @(negedge clk);
    rate_sel = 4'd0;
    do_read();

    // R3/R4 update with alarm hit, extra requests while busy (R10)
    int_en = 3'b011;
    do_update(1'b1);
    for (int k = 0; k < 40; k++) begin
      upd_req = (k % 4 == 0);
      @(negedge clk);
    end
    upd_req = 1'b0;
    #1;
    chk(status_c[5:4] == 2'b11 && irq, "R3/R4 update and alarm", status_c[5:4], 3);
    @(negedge clk);
    do_read();
    #1;
    chk(status_c[6:4] == 3'b000 && !irq, "R7 read clears", status_c, 0);
    @(negedge clk);

    // R4 alarm miss
    do_update(1'b0);
    cyc(40);
    #1;
    chk(status_c[5] == 1'b0 && status_c[4] == 1'b1, "R4 alarm miss", status_c[5:4], 1);
    @(negedge clk);

    // R9 repeated update while flag set, then one read
    do_update(1'b0);
    cyc(40);
    do_read();
    cyc(10);
    #1;
    chk(status_c[4] == 1'b0, "R9 repeat dropped", status_c[4], 0);
    @(negedge clk);

    // mixed traffic
    int_en = 3'b111;
    for (int k = 0; k < 300; k++) begin
      rate_sel = 4'(($urandom % 2) ? 3 + ($urandom % 5) : ($urandom % 3));
      alarm_match = $urandom % 2;
      upd_req = ($urandom % 8 == 0);
      stat_rd = ($urandom % 6 == 0);
      int_en = 3'($urandom);
      @(negedge clk);
    end
    upd_req = 1'b0; stat_rd = 1'b0;
    cyc(50);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule